// File: doc/BRIEF.md
# Gated Oscillator Frequency Counter

This block turns the rate of a free-running oscillator into a number. On a start request it switches the oscillator on and opens a gate window of a fixed number of system-clock cycles. While the window is open, a counter clocked by the oscillator itself counts its rising edges. When the window closes, the oscillator is switched off. The frozen count crosses into the system domain as a Gray code through a synchronizer and is published as a result with a valid flag.

The window length is a parameter. A long window (the default is fifty million cycles, which is one second at 50 MHz) gives fine resolution. A short window allows sample rates of several hundred per second. The oscillator is expected to run slower than the system clock. Because its enable is on only during a measurement, the oscillator adds no self-heating between samples. A typical use is a ring-oscillator temperature or voltage monitor, where software converts the count to a physical value.

Top module: `osc_freq_meter`

## Requirements
- R1: After reset, osc_en is 0, count_valid is 0 and count is 0.
- R2: A start seen while idle raises osc_en on the next system clock edge, and count_valid falls on that same edge.
- R3: osc_en stays high for exactly GATE_TICKS system cycles per measurement, and it is low whenever no measurement is in progress.
- R4: The published count equals the number of rising edges of osc_in that occurred while osc_en was high.
- R5: The edge counter saturates at 2^CNT_W-1 instead of wrapping, so a fast input reports the all-ones value.
- R6: count_valid rises exactly SETTLE_CYC system cycles after osc_en falls.
- R7: count and count_valid hold their values until the next start. A start that arrives during a measurement or the drain period that follows it is ignored: it changes neither the window, nor the timing of valid, nor the result.
- R8: A start issued right after a result restarts from zero, so the new result contains no edges from the previous window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the gate window is timed on it |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Measurement request, sampled on clk |
| osc_in | input | 1 | Oscillator output whose rising edges are counted |
| osc_en | output | 1 | Oscillator enable, high only during the gate window |
| count | output | CNT_W | Edge count of the last completed window |
| count_valid | output | 1 | High while count holds a completed result |

## Verification
On every cycle the assertions track the following: the length of each enable window, the delay from the end of the window to valid, the reaction to an accepted start, the stability of the result while idle, and the monotonic growth of the synchronized count during a window. Monotonic growth rules out wrapping and Gray-decode glitches. Only the bench scenarios can show that the published number matches the actual edge count. They do this for several oscillator rates, including one fast enough to saturate the counter, for a start ignored mid-window, and for a back-to-back restart where stale edges would show up.

// File: rtl/ofm_pkg.sv
package ofm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GATE  = 2'd1,
    ST_DRAIN = 2'd2
  } ofm_state_e;

  // binary to reflected Gray code
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray code back to binary (prefix xor toward the LSB)
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    b = b ^ (b >> 1);
    b = b ^ (b >> 2);
    b = b ^ (b >> 4);
    b = b ^ (b >> 8);
    b = b ^ (b >> 16);
    return b;
  endfunction

  // increment that sticks at the ceiling
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] ceil_v);
    return (v >= ceil_v) ? v : v + 32'd1;
  endfunction

  // window stays open while the next tick is still below the length
  function automatic logic window_open(input logic [31:0] ticks_done, input logic [31:0] len);
    return (ticks_done + 32'd1) < len;
  endfunction

endpackage

// File: rtl/ofm_gate_timer.sv
module ofm_gate_timer
  import ofm_pkg::*;
#(
  parameter int REF_W      = 26,
  parameter int GATE_TICKS = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic win_last
);

  logic [REF_W-1:0] ref_q;

  always_comb win_last = run && !window_open(32'(ref_q), 32'(GATE_TICKS));

  // reload to zero at the end of each window and while stopped
  always_ff @(posedge clk) begin
    if (rst || !run || win_last) ref_q <= '0;
    else                         ref_q <= ref_q + 1'b1;
  end

endmodule

// File: rtl/ofm_edge_counter.sv
module ofm_edge_counter
  import ofm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             osc_clk,
  input  logic             clr,
  output logic [CNT_W-1:0] gray_q
);

  localparam logic [31:0] CEIL = 32'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0] bin_q;
  logic [31:0]      nxt_bin;
  logic [31:0]      nxt_gray;

  always_comb begin
    nxt_bin  = sat_inc(32'(bin_q), CEIL);
    nxt_gray = bin2gray(nxt_bin);
  end

  // clear is a system-domain register; it is released only while the oscillator is idle
  always_ff @(posedge osc_clk or posedge clr) begin
    if (clr) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= nxt_bin[CNT_W-1:0];
      gray_q <= nxt_gray[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/ofm_sync.sv
module ofm_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter
  import ofm_pkg::*;
#(
  parameter int REF_W       = 26,
  parameter int GATE_TICKS  = 50_000_000,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             osc_in,
  output logic             osc_en,
  output logic [CNT_W-1:0] count,
  output logic             count_valid
);

  localparam int DRAIN_W = $clog2(SETTLE_CYC + 1);

  ofm_state_e       state, nxt;
  logic             busy;
  logic             start_ok;
  logic             win_last;
  logic             drain_last;
  logic [DRAIN_W-1:0] drain_cnt;
  logic             osc_clr_q;
  logic [CNT_W-1:0] osc_gray;
  logic [CNT_W-1:0] sync_gray;
  logic [CNT_W-1:0] sync_bin;
  logic [31:0]      dec32;

  // named internal events
  assign busy       = (state != ST_IDLE);
  assign start_ok   = start && !busy;
  assign drain_last = (state == ST_DRAIN) && (drain_cnt == DRAIN_W'(SETTLE_CYC - 1));

  ofm_gate_timer #(
    .REF_W      (REF_W),
    .GATE_TICKS (GATE_TICKS)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (state == ST_GATE),
    .win_last (win_last)
  );

  ofm_edge_counter #(
    .CNT_W (CNT_W)
  ) u_edges (
    .osc_clk (osc_in),
    .clr     (osc_clr_q),
    .gray_q  (osc_gray)
  );

  ofm_sync #(
    .W      (CNT_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (osc_gray),
    .q   (sync_gray)
  );

  always_comb begin
    dec32    = gray2bin(32'(sync_gray));
    sync_bin = dec32[CNT_W-1:0];
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start)      nxt = ST_GATE;
      ST_GATE:  if (win_last)   nxt = ST_DRAIN;
      ST_DRAIN: if (drain_last) nxt = ST_IDLE;
      default:                  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      osc_en    <= 1'b0;
      osc_clr_q <= 1'b1;
      drain_cnt <= '0;
    end else begin
      state     <= nxt;
      osc_en    <= (nxt == ST_GATE);
      osc_clr_q <= (nxt == ST_IDLE);
      drain_cnt <= (state == ST_DRAIN) ? drain_cnt + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count       <= '0;
      count_valid <= 1'b0;
    end else if (start_ok) begin
      count_valid <= 1'b0;
    end else if (drain_last) begin
      count       <= sync_bin;
      count_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/ofm_checker.sv
module ofm_checker #(
  parameter int GATE_TICKS  = 50_000_000,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             osc_en,
  input logic [CNT_W-1:0] count,
  input logic             count_valid,
  input logic             busy,
  input logic [CNT_W-1:0] sync_bin
);

  int unsigned en_run;
  int unsigned off_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_run  <= 0;
      off_run <= 0;
    end else begin
      en_run  <= osc_en ? en_run + 1 : 0;
      off_run <= osc_en ? 0 : ((off_run < 1000) ? off_run + 1 : off_run);
    end
  end

  AST_EN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_en) |-> en_run == GATE_TICKS); // R3

  AST_EN_BOUND: assert property (@(posedge clk) disable iff (rst)
    osc_en |-> en_run < GATE_TICKS); // R3

  AST_EN_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !osc_en); // R3

  AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (osc_en && !count_valid)); // R2

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(count_valid) |-> off_run == SETTLE_CYC); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (count_valid && !start) |=> (count_valid && $stable(count))); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (osc_en && en_run > SYNC_STAGES + 1) |=> sync_bin >= $past(sync_bin)); // R5

endmodule

bind osc_freq_meter ofm_checker #(
  .GATE_TICKS  (GATE_TICKS),
  .CNT_W       (CNT_W),
  .SYNC_STAGES (SYNC_STAGES),
  .SETTLE_CYC  (SETTLE_CYC)
) u_ofm_checker (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .osc_en      (osc_en),
  .count       (count),
  .count_valid (count_valid),
  .busy        (busy),
  .sync_bin    (sync_bin)
);

// File: tb/osc_freq_meter_bench.sv
module osc_freq_meter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int GATE       = 600;
  localparam int CW         = 8;
  localparam int SETTLE     = 4;
  localparam int MAXC       = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic          osc_in;
  logic          osc_en;
  logic [CW-1:0] count;
  logic          count_valid;

  int checks = 0;
  int errors = 0;
  int osc_half = 27;
  int edge_cnt = 0;
  int cyc = 0;
  bit finished = 0;
  int exp_q[$];

  osc_freq_meter #(
    .REF_W       (12),
    .GATE_TICKS  (GATE),
    .CNT_W       (CW),
    .SYNC_STAGES (2),
    .SETTLE_CYC  (SETTLE)
  ) u_osc_freq_meter (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .osc_in      (osc_in),
    .osc_en      (osc_en),
    .count       (count),
    .count_valid (count_valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // oscillator model: toggles only while enabled; odd half period keeps rises off clock edges
  initial begin
    osc_in = 1'b0;
    forever begin
      if (osc_en === 1'b1) begin
        #(osc_half);
        if (osc_en === 1'b1) begin
          osc_in = 1'b1;
          #(osc_half);
          osc_in = 1'b0;
        end
      end else begin
        @(posedge osc_en);
      end
    end
  end

  always @(posedge osc_in) edge_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: window length, valid latency, result vs scoreboard
  int  en_len = 0;
  int  fall_cyc = 0;
  bit  prev_en = 0;
  bit  prev_valid = 0;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst === 1'b0) begin
        if (osc_en) en_len++;
        if (prev_en && !osc_en) begin
          check(en_len == GATE, "R3 enable length", en_len, GATE);
          fall_cyc = cyc;
        end
        if (!prev_en && osc_en) en_len = 1;
        if (count_valid && !prev_valid) begin
          check(cyc - fall_cyc == SETTLE, "R6 valid latency", cyc - fall_cyc, SETTLE);
          if (exp_q.size() == 0) begin
            check(0, "R4 unexpected result", int'(count), -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            check(int'(count) == e, "R4/R5 count", int'(count), e);
          end
        end
        prev_en    = osc_en;
        prev_valid = count_valid;
      end
    end
  end

  // driver: one measurement, optional ignored start mid-window
  task automatic measure(input int half, input bit extra_start, input string tag);
    int e;
    osc_half = half;
    edge_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(osc_en == 1'b1, {"R2 enable rises ", tag}, int'(osc_en), 1);
    check(count_valid == 1'b0, {"R2 valid drops ", tag}, int'(count_valid), 0);
    if (extra_start) begin
      repeat (200) @(negedge clk);
      start = 1'b1; // R7 ignored while measuring
      @(negedge clk);
      start = 1'b0;
    end
    while (osc_en) @(negedge clk);
    e = (edge_cnt > MAXC) ? MAXC : edge_cnt;
    exp_q.push_back(e);
    while (!count_valid) @(negedge clk);
  endtask

  initial begin
    logic [CW-1:0] held;
    rst   = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(osc_en == 1'b0, "R1 reset osc_en", int'(osc_en), 0);
    check(count_valid == 1'b0, "R1 reset valid", int'(count_valid), 0);
    check(count == '0, "R1 reset count", int'(count), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(osc_en == 1'b0, "R3 idle enable low", int'(osc_en), 0);

    measure(27, 1'b0, "slow");          // R4
    repeat (10) @(negedge clk);
    measure(21, 1'b1, "ignored start"); // R7
    held = count;
    repeat (40) @(negedge clk);
    check(count == held && count_valid, "R7 result held", int'(count), int'(held));
    check(osc_en == 1'b0, "R7 idle enable", int'(osc_en), 0);
    measure(11, 1'b0, "saturating");    // R5
    measure(33, 1'b0, "back to back");  // R8
    measure(17, 1'b0, "back to back 2");// R8
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule